// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block is the feedback divider of an integer-N frequency synthesizer. It drives the modulus-control line of a dual-modulus prescaler and counts the prescaler's output pulses, so that one divided pulse leaves the block for every N = B·P + A input cycles. A swallow counter (A) holds the prescaler in its divide-by-(P+1) mode for the first A prescaler cycles of every output period. A main counter (B) sets how many prescaler cycles make up the period.

A behavioural model of the P/(P+1) prescaler is built in, clocked by the input clock. As a result, the whole ratio can be observed against that one clock. A new A, B and prescaler selection is captured on a load strobe and held in a staging register. The new values become active only when the current output period ends, so no period is ever cut short or stretched. A combination that the counters cannot realise is refused and flagged.

Top module: `psw_divider`

## Requirements
- R1: After reset, div_pulse and cfg_bad are 0 and the active setting is A=2, B=5, P=8, so mod_ctl is 1 and the first full period lasts 42 clock cycles.
- R2: Consecutive div_pulse assertions are exactly B·P + A clock cycles apart for the active setting.
- R3: div_pulse is high for exactly one clock cycle per output period.
- R4: mod_ctl is high for the first A prescaler cycles of every period, which is A·(P+1) clock cycles per period.
- R5: The prescaler divides by P+1 while mod_ctl is high and by P otherwise, and pre_tick pulses once per prescaler cycle, giving B pulses per output period.
- R6: The prescaler select field ld_psel encodes P as 0→8, 1→16, 2→32, 3→64.
- R7: Values sampled when ld_stb is high take effect at the next period boundary. The period in progress keeps its old length, and the period that follows uses the new values.
- R8: A load with B < A or B < 3 is discarded, and cfg_bad is 1 from the cycle after it. The next valid load clears cfg_bad and is applied.
- R9: mod_ctl changes only in the clock cycle that follows a pre_tick pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input (RF-side) clock that the prescaler divides |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_stb | input | 1 | One-cycle strobe that samples ld_a, ld_b, ld_psel |
| ld_a | input | 6 | Swallow count A |
| ld_b | input | 13 | Main count B |
| ld_psel | input | 2 | Prescaler modulus select |
| mod_ctl | output | 1 | Modulus control: 1 selects P+1, 0 selects P |
| pre_tick | output | 1 | One-cycle pulse at the end of each prescaler cycle |
| div_pulse | output | 1 | Divided output, one cycle wide, once per N cycles |
| cfg_bad | output | 1 | Last load was rejected as unrealisable |

## Verification
A swallow counter holding a wrong value shows up in the same period as a wrong number of mod_ctl-high cycles, and as a pulse spacing that is off by a multiple of one clock. A wrong main count changes the number of pre_tick pulses and shifts the period by whole multiples of P. A staging error that commits early splits a period, and the pulse spacing shows it within the period in which the load arrives. A staging error that fails to commit shows up one period later, when the spacing stays at the old ratio. Every period is timed from one pulse to the next, so any of these faults appears within two output periods of its cause.

// File: rtl/psw_pkg.sv
package psw_pkg;
  localparam int A_W   = 6;
  localparam int B_W   = 13;
  localparam int SEL_W = 2;
  localparam int P_LOG2_MIN = 3;
  localparam int PC_W  = P_LOG2_MIN + (1 << SEL_W);
  localparam int B_MIN = 3;

  typedef struct packed {
    logic [A_W-1:0]   a;
    logic [B_W-1:0]   b;
    logic [SEL_W-1:0] sel;
  } psw_cfg_t;

  // Prescaler base modulus P for a select code.
  function automatic logic [PC_W-1:0] modulus_of(input logic [SEL_W-1:0] sel);
    return PC_W'(1 << P_LOG2_MIN) << sel;
  endfunction

  // A setting is realisable when B covers all swallow cycles and meets the minimum.
  function automatic logic cfg_ok(input logic [A_W-1:0] a, input logic [B_W-1:0] b);
    return (b >= B_W'(a)) && (b >= B_W'(B_MIN));
  endfunction
endpackage

// File: rtl/psw_prescaler.sv
module psw_prescaler
  import psw_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mod_hi,
  input  logic [PC_W-1:0] p_val,
  output logic            tick
);
  logic [PC_W-1:0] cnt_q;
  logic [PC_W-1:0] last_w;

  // Terminal count is P for the P+1 mode, P-1 otherwise.
  assign last_w = mod_hi ? p_val : (p_val - PC_W'(1));
  assign tick   = (cnt_q == last_w);

  always_ff @(posedge clk) begin
    if (!rst_n)    cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + PC_W'(1);
  end
endmodule

// File: rtl/psw_swallow.sv
module psw_swallow
  import psw_pkg::*;
#(
  parameter psw_cfg_t RST_CFG = '0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tick,
  input  psw_cfg_t reload_cfg,
  output logic     mod_hi,
  output logic     period_end
);
  logic [A_W-1:0] a_cnt_q;
  logic [B_W-1:0] b_cnt_q;

  assign mod_hi     = (a_cnt_q != '0);
  assign period_end = tick && (b_cnt_q == B_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      a_cnt_q <= RST_CFG.a;
      b_cnt_q <= RST_CFG.b;
    end else if (period_end) begin
      a_cnt_q <= reload_cfg.a;
      b_cnt_q <= reload_cfg.b;
    end else if (tick) begin
      b_cnt_q <= b_cnt_q - B_W'(1);
      if (mod_hi) a_cnt_q <= a_cnt_q - A_W'(1);
    end
  end
endmodule

// File: rtl/psw_cfg_stage.sv
module psw_cfg_stage
  import psw_pkg::*;
#(
  parameter psw_cfg_t RST_CFG = '0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     ld_stb,
  input  psw_cfg_t ld_cfg,
  input  logic     period_end,
  output psw_cfg_t act_cfg,
  output psw_cfg_t next_cfg,
  output logic     cfg_bad
);
  psw_cfg_t pend_q;
  logic     pend_v_q;
  logic     ld_ok_w;

  assign ld_ok_w  = cfg_ok(ld_cfg.a, ld_cfg.b);
  assign next_cfg = pend_v_q ? pend_q : act_cfg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_cfg  <= RST_CFG;
      pend_q   <= RST_CFG;
      pend_v_q <= 1'b0;
      cfg_bad  <= 1'b0;
    end else begin
      if (period_end) begin
        if (pend_v_q) act_cfg <= pend_q;
        pend_v_q <= 1'b0;
      end
      if (ld_stb) begin
        cfg_bad <= !ld_ok_w;
        if (ld_ok_w) begin
          pend_q   <= ld_cfg;
          pend_v_q <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/psw_divider.sv
module psw_divider
  import psw_pkg::*;
#(
  parameter int RST_A   = 2,
  parameter int RST_B   = 5,
  parameter int RST_SEL = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld_stb,
  input  logic [A_W-1:0]   ld_a,
  input  logic [B_W-1:0]   ld_b,
  input  logic [SEL_W-1:0] ld_psel,
  output logic             mod_ctl,
  output logic             pre_tick,
  output logic             div_pulse,
  output logic             cfg_bad
);
  localparam psw_cfg_t RST_CFG = '{a: A_W'(RST_A), b: B_W'(RST_B), sel: SEL_W'(RST_SEL)};

  psw_cfg_t        ld_cfg;
  psw_cfg_t        act_cfg;
  psw_cfg_t        next_cfg;
  logic            period_end;
  logic            mod_hi;
  logic [PC_W-1:0] p_val;

  assign ld_cfg = '{a: ld_a, b: ld_b, sel: ld_psel};
  assign p_val  = modulus_of(act_cfg.sel);

  psw_cfg_stage #(.RST_CFG(RST_CFG)) u_cfg (
    .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_cfg(ld_cfg),
    .period_end(period_end), .act_cfg(act_cfg), .next_cfg(next_cfg),
    .cfg_bad(cfg_bad)
  );

  psw_prescaler u_pre (
    .clk(clk), .rst_n(rst_n), .mod_hi(mod_hi), .p_val(p_val), .tick(pre_tick)
  );

  psw_swallow #(.RST_CFG(RST_CFG)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(pre_tick), .reload_cfg(next_cfg),
    .mod_hi(mod_hi), .period_end(period_end)
  );

  assign mod_ctl = mod_hi;

  always_ff @(posedge clk) begin
    if (!rst_n) div_pulse <= 1'b0;
    else        div_pulse <= period_end;
  end
endmodule

// File: rtl/psw_divider_chk.sv
module psw_divider_chk
  import psw_pkg::*;
(
  input logic     clk,
  input logic     rst_n,
  input logic     ld_stb,
  input logic     mod_ctl,
  input logic     pre_tick,
  input logic     div_pulse,
  input logic     cfg_bad,
  input logic     period_end,
  input psw_cfg_t act_cfg
);
  // R3
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  // R2
  pulse_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |-> $past(pre_tick));

  // R9
  mod_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mod_ctl) |-> $past(pre_tick));

  // R7
  commit_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(act_cfg) |-> $past(period_end));

  // R8
  bad_on_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_bad) |-> $past(ld_stb));

  // R8
  active_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(div_pulse) |-> (act_cfg.b >= B_W'(act_cfg.a)) && (act_cfg.b >= B_W'(B_MIN)));
endmodule

bind psw_divider psw_divider_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .mod_ctl(mod_ctl),
  .pre_tick(pre_tick), .div_pulse(div_pulse), .cfg_bad(cfg_bad),
  .period_end(period_end), .act_cfg(act_cfg)
);

// File: tb/tb_psw_divider.sv
module tb_psw_divider;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        ld_stb;
  logic [5:0]  ld_a;
  logic [12:0] ld_b;
  logic [1:0]  ld_psel;
  logic        mod_ctl, pre_tick, div_pulse, cfg_bad;

  int n_chk  = 0;
  int n_fail = 0;
  int cur_a  = 2;
  int cur_b  = 5;
  int cur_s  = 0;
  bit hung   = 0;

  always #10 clk = ~clk;

  psw_divider dut (
    .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_a(ld_a), .ld_b(ld_b),
    .ld_psel(ld_psel), .mod_ctl(mod_ctl), .pre_tick(pre_tick),
    .div_pulse(div_pulse), .cfg_bad(cfg_bad)
  );

  function automatic int ratio(int a, int b, int s);
    return b * (8 << s) + a;
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic sync_pulse();
    int k = 0;
    do begin
      @(posedge clk); #1; k++;
    end while (!div_pulse && k < 5000);
    if (!div_pulse) hung = 1;
  endtask

  // Starts on a sample where div_pulse is high; ends on the next such sample.
  // Optionally drives a load during the first cycle of the period.
  task automatic period(input bit do_ld, input int a, input int b, input int s,
                        output int n, output int mh, output int tk, output int badmod);
    bit prev_t, prev_m, done;
    n = 1; mh = int'(mod_ctl); tk = int'(pre_tick); badmod = 0;
    prev_t = pre_tick; prev_m = mod_ctl; done = 0;
    if (do_ld) begin
      ld_a = 6'(a); ld_b = 13'(b); ld_psel = 2'(s); ld_stb = 1'b1;
    end
    while (!done) begin
      @(posedge clk); #1;
      ld_stb = 1'b0;
      if (div_pulse) done = 1;
      else begin
        n++;
        mh += int'(mod_ctl);
        tk += int'(pre_tick);
        if (mod_ctl != prev_m && !prev_t) badmod++;
        prev_t = pre_tick; prev_m = mod_ctl;
        if (n > 20000) begin hung = 1; done = 1; end
      end
    end
  endtask

  task automatic run_cfg(int a, int b, int s);
    int n, mh, tk, bm, pa, exp_n;
    bit ok;
    ok = (b >= a) && (b >= 3);
    period(1'b1, a, b, s, n, mh, tk, bm);
    chk($sformatf("R7 old period a=%0d b=%0d s=%0d", a, b, s), n, ratio(cur_a, cur_b, cur_s));
    chk("R8 cfg_bad after load", int'(cfg_bad), int'(!ok));
    if (ok) begin cur_a = a; cur_b = b; cur_s = s; end
    period(1'b0, 0, 0, 0, n, mh, tk, bm);
    exp_n = ratio(cur_a, cur_b, cur_s);
    pa = 8 << cur_s;
    chk($sformatf("R2 period a=%0d b=%0d P=%0d", cur_a, cur_b, pa), n, exp_n);
    if (!ok) chk("R8 rejected load kept old ratio", n, exp_n);
    chk("R3 pulse width one", int'(n > 1), 1);
    chk($sformatf("R4 mod_ctl high cycles a=%0d P=%0d", cur_a, pa), mh, cur_a * (pa + 1));
    chk($sformatf("R5 prescaler pulses b=%0d", cur_b), tk, cur_b);
    chk("R9 mod_ctl change without prior tick", bm, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int n, mh, tk, bm;
    rst_n = 1'b0; ld_stb = 1'b0; ld_a = '0; ld_b = '0; ld_psel = '0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 div_pulse in reset", int'(div_pulse), 0);
    chk("R1 cfg_bad in reset", int'(cfg_bad), 0);
    chk("R1 mod_ctl in reset", int'(mod_ctl), 1);
    rst_n = 1'b1;
    sync_pulse();
    period(1'b0, 0, 0, 0, n, mh, tk, bm);
    chk("R1 default period", n, 42);
    chk("R4 default mod_ctl cycles", mh, 2 * 9);

    // Near-exhaustive sweep over small counts for the two smaller moduli.
    for (int s = 0; s < 2; s++)
      for (int b = 3; b <= 6; b++)
        for (int a = 0; a <= b; a++)
          if (!hung) run_cfg(a, b, s);

    // R6: larger moduli.
    run_cfg(1, 3, 2);
    chk("R6 select 2 gives P=32", ratio(cur_a, cur_b, cur_s), 97);
    run_cfg(2, 3, 3);
    chk("R6 select 3 gives P=64", ratio(cur_a, cur_b, cur_s), 194);
    run_cfg(0, 4, 3);

    // R8: rejected combinations, then recovery.
    run_cfg(5, 4, 1);
    run_cfg(0, 2, 0);
    run_cfg(2, 2, 1);
    run_cfg(4, 4, 0);
    chk("R8 valid load clears cfg_bad", int'(cfg_bad), 0);

    chk("watchdog", int'(hung), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule